// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation conversion. It drives a trial code to an external comparator and reads back one decision bit per step. It resolves the code from the most significant bit down. Each conversion has two parts: a sample phase, during which a sample strobe holds the analog front end, and then ten decision steps. Each of these phases lasts a programmable number of clock cycles. The final code is kept in a result register. Code 0 stands for ground, and the all-ones code stands for the reference level less one step.

A conversion can begin in three ways: a software start request, an automatic restart in free-running mode, or a rising edge on an auto-trigger input. Every finished conversion sets a pending flag. The interrupt line is that flag masked by an interrupt-enable input. Software clears the flag by writing one, or the flag clears when the interrupt is acknowledged. The enable input gates all activity. While it is low, the block does not convert, its strobes stay quiet, and new channel and reference selections are held back from the front end.

Top module: `sar_sequencer`

## Requirements
- R1: The result equals the input code, for any input held steady during a conversion. In each decision step the trial code keeps all the bits already decided and sets the bit under test. A comparator input of 1 means the analog input is below the trial level, and it clears that bit. The first trial code is 10'h200.
- R2: Each phase lasts div_i+1 clock cycles. div_i is captured when a conversion starts. A conversion is one sample phase (sample_o high) followed by ten decision steps, so busy_o stays high for 11*(div_i+1) cycles. cmp_strobe_o is high on the last cycle of each decision step, and only then.
- R3: ch_o and ref_o take the values of ch_sel_i and ref_sel_i on a clock edge at which en_i is high. They hold their values on every edge at which en_i is low.
- R4: When en_i is low, sample_o and cmp_strobe_o are low in the same cycle. Any conversion in progress is abandoned at the next edge: busy_o falls, result_o is unchanged and flag_o is not set.
- R5: In single mode (free_run_i low), a start_i pulse while idle and enabled begins one conversion. busy_o reads 1 until completion and then returns to 0. A start_i pulse during a conversion is ignored.
- R6: In free-running mode, a new sample phase begins in the cycle right after the last decision, and busy_o stays high across the boundary.
- R7: A rising edge of trig_i while trig_en_i is high and the block is idle starts a conversion. An edge that arrives during a conversion is dropped, not queued. Edges are ignored while trig_en_i is low.
- R8: Completion sets flag_o. flag_clr_i or irq_ack_i clears it, and a completion in the same cycle as a clear leaves it set. irq_o is high exactly when flag_o and ie_i are both high.
- R9: After reset, busy_o, flag_o, irq_o, trial_o, result_o, ch_o and ref_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable |
| start_i | input | 1 | Start request pulse |
| free_run_i | input | 1 | Free-running mode select |
| trig_en_i | input | 1 | Auto-trigger enable |
| trig_i | input | 1 | Auto-trigger source, rising edge starts |
| div_i | input | 4 | Step length minus one, in clock cycles |
| ch_sel_i | input | 3 | Requested channel select |
| ref_sel_i | input | 2 | Requested reference select |
| cmp_i | input | 1 | Comparator: 1 when input is below trial level |
| ie_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one clear of the pending flag |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| ch_o | output | 3 | Channel select applied to front end |
| ref_o | output | 2 | Reference select applied to front end |
| sample_o | output | 1 | Sample-and-hold strobe |
| cmp_strobe_o | output | 1 | Comparator decision strobe |
| trial_o | output | 10 | Trial code to the comparator DAC |
| busy_o | output | 1 | Conversion in progress (start bit readback) |
| result_o | output | 10 | Last completed conversion code |
| flag_o | output | 1 | Conversion-complete pending flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The collision that matters is the completion of a conversion arriving in the same cycle as a software clear or acknowledge of the pending flag. The bench provokes it by watching for the decision strobe on the least significant bit and raising the clear in that same cycle. It then expects the flag to stay set. A second overlap is an auto-trigger or start request that arrives while a conversion is running. The bench judges this by the conversion length and by busy_o returning to idle with no follow-on conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_CONV   = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_step_timer.sv
module sar_step_timer #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] last_cnt,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == last_cnt);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             clr,
  input  logic             cmp_below,
  output logic [RES_W-1:0] trial,
  output logic [RES_W-1:0] result,
  output logic             last
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] mask;
  logic [RES_W-1:0] trial_nxt;

  // per-bit decision: resolve the bit under test, seed the next one below
  for (genvar i = 0; i < RES_W; i++) begin : g_bit
    if (i == RES_W - 1) begin : g_top
      assign trial_nxt[i] = mask[i] ? !cmp_below : trial[i];
    end else begin : g_low
      assign trial_nxt[i] = mask[i]     ? !cmp_below :
                            mask[i + 1] ? 1'b1       : trial[i];
    end
  end

  assign last = mask[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      trial  <= '0;
      mask   <= '0;
      result <= '0;
    end else if (load) begin
      trial <= TOP_BIT;
      mask  <= TOP_BIT;
    end else if (step) begin
      trial <= trial_nxt;
      mask  <= mask >> 1;
      if (mask[0]) result <= trial_nxt;
    end else if (clr) begin
      trial <= '0;
      mask  <= '0;
    end
  end
endmodule

// File: rtl/sar_done_flag.sv
module sar_done_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic ie,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag && ie;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES_W = 10,
  parameter int DIV_W = 4,
  parameter int CH_W  = 3,
  parameter int REF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             free_run_i,
  input  logic             trig_en_i,
  input  logic             trig_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CH_W-1:0]  ch_sel_i,
  input  logic [REF_W-1:0] ref_sel_i,
  input  logic             cmp_i,
  input  logic             ie_i,
  input  logic             flag_clr_i,
  input  logic             irq_ack_i,
  output logic [CH_W-1:0]  ch_o,
  output logic [REF_W-1:0] ref_o,
  output logic             sample_o,
  output logic             cmp_strobe_o,
  output logic [RES_W-1:0] trial_o,
  output logic             busy_o,
  output logic [RES_W-1:0] result_o,
  output logic             flag_o,
  output logic             irq_o
);
  import sar_pkg::*;

  phase_t           phase;
  logic [DIV_W-1:0] div_q;
  logic             trig_q;
  logic             tick;
  logic             run;
  logic             go;
  logic             last_bit;
  logic             done;

  assign run          = en_i && (phase != PH_IDLE);
  assign go           = en_i && (phase == PH_IDLE) &&
                        (start_i || (trig_en_i && trig_i && !trig_q));
  assign sample_o     = en_i && (phase == PH_SAMPLE);
  assign cmp_strobe_o = (phase == PH_CONV) && tick;
  assign done         = cmp_strobe_o && last_bit;
  assign busy_o       = (phase != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      div_q  <= '0;
      trig_q <= 1'b0;
      ch_o   <= '0;
      ref_o  <= '0;
    end else begin
      trig_q <= trig_i;
      if (en_i) begin
        ch_o  <= ch_sel_i;
        ref_o <= ref_sel_i;
      end
      if (!en_i) begin
        phase <= PH_IDLE;
      end else begin
        unique case (phase)
          PH_IDLE: if (go) begin
            phase <= PH_SAMPLE;
            div_q <= div_i;
          end
          PH_SAMPLE: if (tick) phase <= PH_CONV;
          PH_CONV: if (done) begin
            if (free_run_i) begin
              phase <= PH_SAMPLE;
              div_q <= div_i;
            end else begin
              phase <= PH_IDLE;
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  sar_step_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .last_cnt (div_q),
    .tick     (tick)
  );

  sar_approx_reg #(.RES_W(RES_W)) u_approx (
    .clk       (clk),
    .rst       (rst),
    .load      (sample_o && tick),
    .step      (cmp_strobe_o),
    .clr       (!en_i || (phase != PH_CONV)),
    .cmp_below (cmp_i),
    .trial     (trial_o),
    .result    (result_o),
    .last      (last_bit)
  );

  sar_done_flag u_flag (
    .clk  (clk),
    .rst  (rst),
    .set  (done),
    .clr  (flag_clr_i || irq_ack_i),
    .ie   (ie_i),
    .flag (flag_o),
    .irq  (irq_o)
  );
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3,
  parameter int REF_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             start_i,
  input logic [CH_W-1:0]  ch_o,
  input logic [REF_W-1:0] ref_o,
  input logic             busy_o,
  input logic             cmp_strobe_o,
  input logic [RES_W-1:0] trial_o,
  input logic             flag_o
);
  // R3: front-end selections frozen while disabled
  assert_sel_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> ($stable(ch_o) && $stable(ref_o)));

  // R4: disabling abandons any conversion
  assert_abort_R4: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !busy_o);

  // R5: idle start request enters a conversion
  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    (start_i && en_i && !busy_o) |=> busy_o);

  // R1: every decision presents a nonzero trial code
  assert_trial_live_R1: assert property (@(posedge clk) disable iff (rst)
    cmp_strobe_o |-> (trial_o != '0));

  // R8: flag only rises after a decision strobe
  assert_flag_src_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(cmp_strobe_o));

  // R8: a normal end of conversion leaves the flag set
  assert_end_flag_R8: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && $past(en_i) && !$past(rst)) |-> flag_o);
endmodule

bind sar_sequencer sar_sequencer_chk #(
  .RES_W(RES_W), .CH_W(CH_W), .REF_W(REF_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .en_i         (en_i),
  .start_i      (start_i),
  .ch_o         (ch_o),
  .ref_o        (ref_o),
  .busy_o       (busy_o),
  .cmp_strobe_o (cmp_strobe_o),
  .trial_o      (trial_o),
  .flag_o       (flag_o)
);

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en_i = 0, start_i = 0, free_run_i = 0, trig_en_i = 0, trig_i = 0;
  logic [3:0] div_i = 0;
  logic [2:0] ch_sel_i = 0;
  logic [1:0] ref_sel_i = 0;
  logic ie_i = 0, flag_clr_i = 0, irq_ack_i = 0;
  logic cmp_i;
  logic [2:0] ch_o;
  logic [1:0] ref_o;
  logic sample_o, cmp_strobe_o, busy_o, flag_o, irq_o;
  logic [9:0] trial_o, result_o;

  int vin = 0;
  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign cmp_i = (vin < int'(trial_o));

  sar_sequencer u_sar_sequencer (
    .clk(clk), .rst(rst), .en_i(en_i), .start_i(start_i), .free_run_i(free_run_i),
    .trig_en_i(trig_en_i), .trig_i(trig_i), .div_i(div_i), .ch_sel_i(ch_sel_i),
    .ref_sel_i(ref_sel_i), .cmp_i(cmp_i), .ie_i(ie_i), .flag_clr_i(flag_clr_i),
    .irq_ack_i(irq_ack_i), .ch_o(ch_o), .ref_o(ref_o), .sample_o(sample_o),
    .cmp_strobe_o(cmp_strobe_o), .trial_o(trial_o), .busy_o(busy_o),
    .result_o(result_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  // behavioural reference model: phase 0 idle, 1 sample, 2 deciding
  int m_ph = 0, m_cnt = 0, m_bit = 0, m_div = 0;
  int m_trial = 0, m_res = 0, m_ch = 0, m_ref = 0;
  bit m_flag = 0, m_trq = 0;

  always @(posedge clk) begin
    bit tick, done, go;
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_bit = 0; m_div = 0; m_trial = 0;
      m_res = 0; m_ch = 0; m_ref = 0; m_flag = 0; m_trq = 0;
    end else begin
      tick = en_i && m_ph != 0 && m_cnt == m_div;
      done = m_ph == 2 && tick && m_bit == 0;
      go   = en_i && m_ph == 0 && (start_i || (trig_en_i && trig_i && !m_trq));
      if (!en_i) m_trial = 0;
      else if (m_ph == 1 && tick) m_trial = 512;
      else if (m_ph == 2 && tick)
        m_trial = (m_bit > 0) ? (((vin >> m_bit) << m_bit) | (1 << (m_bit - 1))) : vin;
      else if (m_ph != 2) m_trial = 0;
      if (done) m_res = vin;
      if (done) m_flag = 1;
      else if (flag_clr_i || irq_ack_i) m_flag = 0;
      if (en_i) begin m_ch = ch_sel_i; m_ref = ref_sel_i; end
      m_trq = trig_i;
      if (!en_i || m_ph == 0 || tick) m_cnt = 0; else m_cnt = m_cnt + 1;
      if (!en_i) m_ph = 0;
      else if (m_ph == 0) begin
        if (go) begin m_ph = 1; m_div = div_i; end
      end else if (m_ph == 1) begin
        if (tick) begin m_ph = 2; m_bit = 9; end
      end else if (tick) begin
        if (m_bit > 0) m_bit = m_bit - 1;
        else if (free_run_i) begin m_ph = 1; m_div = div_i; end
        else m_ph = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int e_samp, e_strb, e_busy, e_irq;
    e_samp = (en_i && m_ph == 1) ? 1 : 0;
    e_strb = (en_i && m_ph == 2 && m_cnt == m_div) ? 1 : 0;
    e_busy = (m_ph != 0) ? 1 : 0;
    e_irq  = (m_flag && ie_i) ? 1 : 0;
    vectors++;
    if (int'(trial_o) != m_trial || int'(result_o) != m_res || int'(sample_o) != e_samp ||
        int'(cmp_strobe_o) != e_strb || int'(busy_o) != e_busy || flag_o != m_flag ||
        int'(irq_o) != e_irq || int'(ch_o) != m_ch || int'(ref_o) != m_ref) begin
      fails++;
      $display("FAIL R1/R2/R3/R5/R8 model: actual trial=%0d res=%0d samp=%0d strb=%0d busy=%0d flag=%0d irq=%0d ch=%0d ref=%0d expected trial=%0d res=%0d samp=%0d strb=%0d busy=%0d flag=%0d irq=%0d ch=%0d ref=%0d",
               trial_o, result_o, sample_o, cmp_strobe_o, busy_o, flag_o, irq_o, ch_o, ref_o,
               m_trial, m_res, e_samp, e_strb, e_busy, m_flag, e_irq, m_ch, m_ref);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 5000) begin n++; cyc(); end
  endtask

  task automatic convert(input int v, input int d);
    int n;
    vin = v; div_i = 4'(d);
    start_i = 1; cyc(); start_i = 0;
    wait_idle(n);
    check(n == 11 * (d + 1), "R2", "conversion length", n, 11 * (d + 1));
    check(int'(result_o) == v, "R1", "result code", int'(result_o), v);
    check(flag_o == 1, "R8", "flag after completion", int'(flag_o), 1);
  endtask

  initial begin
    int n;
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R9 reset state
    check(!busy_o && !flag_o && !irq_o && trial_o == 0 && result_o == 0 && ch_o == 0 && ref_o == 0,
          "R9", "reset outputs", int'(busy_o) + int'(flag_o) + int'(trial_o), 0);
    // R3 selections blocked while disabled
    ch_sel_i = 5; ref_sel_i = 2;
    repeat (3) cyc();
    check(ch_o == 0, "R3", "ch held while disabled", int'(ch_o), 0);
    en_i = 1; cyc();
    check(ch_o == 5 && ref_o == 2, "R3", "ch applied once enabled", int'(ch_o), 5);
    en_i = 0; ch_sel_i = 1; repeat (2) cyc();
    check(ch_o == 5, "R3", "ch frozen after disable", int'(ch_o), 5);
    en_i = 1; cyc();
    // R1/R2 single conversions across codes and step lengths
    convert(0, 0);
    convert(1023, 0);
    convert(512, 2);
    convert(341, 1);
    convert(682, 3);
    flag_clr_i = 1; cyc(); flag_clr_i = 0;
    check(flag_o == 0, "R8", "write-one clear", int'(flag_o), 0);
    // R8 irq masking and acknowledge
    ie_i = 1; convert(100, 0); cyc();
    check(irq_o == 1, "R8", "irq with enable", int'(irq_o), 1);
    irq_ack_i = 1; cyc(); irq_ack_i = 0;
    check(flag_o == 0 && irq_o == 0, "R8", "ack clears", int'(flag_o), 0);
    ie_i = 0;
    // R5 start during conversion is ignored
    vin = 200; div_i = 0; start_i = 1; cyc(); start_i = 0;
    repeat (4) cyc();
    start_i = 1; cyc(); start_i = 0;
    wait_idle(n);
    repeat (3) cyc();
    check(busy_o == 0, "R5", "no restart from mid-conversion start", int'(busy_o), 0);
    check(result_o == 200, "R5", "result after single conversion", int'(result_o), 200);
    flag_clr_i = 1; cyc(); flag_clr_i = 0;
    // R8 collision: completion in same cycle as clear
    vin = 457; div_i = 1; start_i = 1; cyc(); start_i = 0;
    n = 0;
    while (!(cmp_strobe_o && trial_o[0]) && n < 200) begin n++; cyc(); end
    flag_clr_i = 1; cyc(); flag_clr_i = 0;
    check(flag_o == 1, "R8", "set wins over clear", int'(flag_o), 1);
    flag_clr_i = 1; cyc(); flag_clr_i = 0;
    // R6 free-running
    free_run_i = 1; vin = 300; div_i = 0; start_i = 1; cyc(); start_i = 0;
    n = 0;
    for (int i = 0; i < 30; i++) begin cyc(); if (busy_o) n++; end
    check(n == 30, "R6", "busy held across restarts", n, 30);
    free_run_i = 0;
    wait_idle(n);
    check(result_o == 300, "R6", "free-run result", int'(result_o), 300);
    // R7 auto-trigger
    trig_i = 1; cyc(); trig_i = 0; cyc();
    check(busy_o == 0, "R7", "trigger ignored when disabled", int'(busy_o), 0);
    trig_en_i = 1; vin = 77;
    trig_i = 1; cyc(); trig_i = 0;
    check(busy_o == 1, "R7", "trigger edge starts", int'(busy_o), 1);
    repeat (4) cyc();
    trig_i = 1; cyc(); trig_i = 0;
    wait_idle(n);
    repeat (4) cyc();
    check(busy_o == 0, "R7", "edge during conversion dropped", int'(busy_o), 0);
    check(result_o == 77, "R7", "triggered result", int'(result_o), 77);
    trig_en_i = 0;
    flag_clr_i = 1; cyc(); flag_clr_i = 0;
    // R4 abort by disable
    vin = 900; div_i = 1; start_i = 1; cyc(); start_i = 0;
    repeat (9) cyc();
    en_i = 0;
    #1;
    check(sample_o == 0 && cmp_strobe_o == 0, "R4", "strobes quiet when disabled",
          int'(sample_o) + int'(cmp_strobe_o), 0);
    cyc();
    check(busy_o == 0, "R4", "conversion abandoned", int'(busy_o), 0);
    repeat (3) cyc();
    check(result_o == 77 && flag_o == 0, "R4", "result and flag untouched", int'(result_o), 77);
    en_i = 1; repeat (2) cyc();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule